// File: doc/BRIEF.md
# Prescaled Gated Period-Match Timer

This block is a timer built from two 16-bit count segments. They run either as two independent 16-bit timers or, when paired, as one 32-bit timer with the upper segment taking the carry of the lower one. Each segment has its own period register. One control word sets the enable, the gate mode, the pairing, the clock source and a prescale ratio. The counter advances on prescaled ticks. A tick source is either every cycle of the system clock or each rising edge of an external clock input that has been resynchronized into the system clock domain.

When the count equals the period, the counter keeps that value for one full prescale period, and software can still read it there. On the next tick the counter returns to zero, and a one-cycle match pulse marks that cycle. In gate mode, ticks are counted only while a synchronized gate input is high. Software reaches the block through a flat write port and a combinational read port.

Top module: `gated_period_timer`

## Requirements
- R1: After reset the control word reads 0, both count segments read 0, both period segments read 0xFFFF, and match_pulse is 0.
- R2: Control word bit positions: 15 enable, 7 gate mode, 6:4 prescale code, 3 pairing, 1 external clock source; all other bits read 0. Address 0 writes the word. Address 1 ORs the written bits in. Address 2 clears the written bits.
- R3: Prescale codes 0..7 select ratios 1, 2, 4, 8, 16, 32, 64, 256. With the internal source the count rises by one on every ratio-th system clock edge after enable.
- R4: Once the count reaches the period, it holds that value until the next prescaled tick, which sets it to 0. Below the period, each tick adds exactly one.
- R5: match_pulse bit 0 (lower or paired timer) or bit 1 (upper 16-bit timer) is high for exactly the cycle in which that counter has just returned to 0 after a match.
- R6: In paired mode, a write to address 3 (count low) or address 5 (period low) loads all 32 bits, a read of address 3 returns the full 32-bit count, the carry passes from the lower to the upper segment, and the wrap follows the 32-bit comparison.
- R7: In unpaired mode, address 3/5 hold the lower segment and address 4/6 the upper one. Both advance on the same tick, and each wraps on its own period.
- R8: With gate mode set, ticks are counted only while the gate input, delayed by a two-flop synchronizer, is high.
- R9: Clearing the enable freezes the count. The prescale counter is cleared while the timer is off and on any count or control write, so the first tick after re-enabling comes a full ratio of source events later.
- R10: With the external source, each rising edge of ext_clk_in counts as one source event. It takes effect on the third system clock edge after the input changes, and a held level counts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 ctrl, 1 set, 2 clear, 3 count low, 4 count high, 5 period low, 6 period high) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| ext_clk_in | input | 1 | Asynchronous external count source |
| gate_in | input | 1 | Asynchronous gate level |
| match_pulse | output | 2 | One-cycle wrap pulses, bit 0 lower/paired, bit 1 upper |

## Verification
The hardest states to reach from the ports are the hold window after a match and the prescaler phase left behind by a disable. The first is only observable when period, ratio and sampling edge all line up. The second only shows as a one-edge difference in when the first tick comes after re-enabling. The bench sets a small period with ratio 2 and samples on each edge from the tenth to the thirteenth. It also stops the timer in the middle of a prescale period and counts edges to the next increment. A 32-bit count loaded just below a carry and just below the all-ones period covers the pairing carry and the 32-bit wrap in a few cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W  = 16;
  localparam int PRE_W   = 8;
  localparam int B_ON    = 15;
  localparam int B_GATE  = 7;
  localparam int PS_LSB  = 4;
  localparam int B_PAIR  = 3;
  localparam int B_EXT   = 1;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'h80FA;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_SET    = 3'd1,
    A_CLR    = 3'd2,
    A_CNT_LO = 3'd3,
    A_CNT_HI = 3'd4,
    A_PER_LO = 3'd5,
    A_PER_HI = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic       on;
    logic       gate;
    logic [2:0] ps;
    logic       pair;
    logic       ext;
  } cfg_t;

  function automatic cfg_t cfg_decode(input logic [CTRL_W-1:0] c);
    cfg_t r;
    r.on   = c[B_ON];
    r.gate = c[B_GATE];
    r.ps   = c[PS_LSB+2:PS_LSB];
    r.pair = c[B_PAIR];
    r.ext  = c[B_EXT];
    return r;
  endfunction

  function automatic logic [PRE_W:0] ps_ratio(input logic [2:0] code);
    logic [PRE_W:0] r;
    if (code == 3'd7) r = (PRE_W+1)'(256);
    else              r = (PRE_W+1)'(1) << code;
    return r;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_next(input logic [1:0] op,
                                                  input logic [CTRL_W-1:0] cur,
                                                  input logic [CTRL_W-1:0] w);
    logic [CTRL_W-1:0] m;
    m = w & CTRL_MASK;
    case (op)
      2'd1:    return cur | m;
      2'd2:    return cur & ~m;
      default: return m;
    endcase
  endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             evt,
  input  logic [2:0]       ps_code,
  output logic             tick,
  output logic [PRE_W-1:0] pre_cnt,
  output logic [PRE_W:0]   ratio
);
  logic last;

  assign ratio = ps_ratio(ps_code);
  assign last  = ({1'b0, pre_cnt} == ratio - 1'b1);
  assign tick  = evt && !clear && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_cnt <= '0;
    else if (clear)    pre_cnt <= '0;
    else if (evt) begin
      if (last)        pre_cnt <= '0;
      else             pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_segment.sv
module tmr_segment #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         wrap,
  input  logic         step,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (tick) begin
      if (wrap)        cnt <= '0;
      else if (step)   cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
  import tmr_pkg::*;
#(
  parameter int SEG_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = 2 * SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_clk_in,
  input  logic              gate_in,
  output logic [1:0]        match_pulse
);
  logic [CTRL_W-1:0] ctrl_q;
  cfg_t              cfg;
  logic              ctrl_on, gate_en, pair_mode;
  logic              ctrl_wr, cnt_wr;
  logic              gate_s, ext_s, ext_prev, ext_rise;
  logic              src_evt, evt, pre_clear, tick;
  logic [PRE_W-1:0]  pre_cnt;
  logic [PRE_W:0]    ratio;
  logic [SEG_W-1:0]  per_q [2];
  logic [SEG_W-1:0]  seg_cnt [2];
  logic [SEG_W-1:0]  seg_val [2];
  logic [1:0]        seg_load, seg_wrap, seg_step;
  logic [DATA_W-1:0] cnt_full, per_full;
  logic              hit32, hit_lo, hit_hi, wrap_lo;
  logic [1:0]        match_q;

  assign cfg       = cfg_decode(ctrl_q);
  assign ctrl_on   = cfg.on;
  assign gate_en   = cfg.gate;
  assign pair_mode = cfg.pair;

  assign ctrl_wr = wr_en && (addr == A_CTRL || addr == A_SET || addr == A_CLR);
  assign cnt_wr  = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_next(addr[1:0], ctrl_q, wdata[CTRL_W-1:0]);
  end

  tmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .din(gate_in), .dout(gate_s));
  tmr_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk_in), .dout(ext_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= 1'b0;
    else        ext_prev <= ext_s;
  end
  assign ext_rise = ext_s && !ext_prev;

  assign src_evt   = cfg.ext ? ext_rise : 1'b1;
  assign evt       = ctrl_on && (!gate_en || gate_s) && src_evt;
  assign pre_clear = !ctrl_on || cnt_wr || ctrl_wr;

  tmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clear(pre_clear), .evt(evt),
    .ps_code(cfg.ps), .tick(tick), .pre_cnt(pre_cnt), .ratio(ratio));

  assign cnt_full = {seg_cnt[1], seg_cnt[0]};
  assign per_full = {per_q[1], per_q[0]};
  assign hit32    = (cnt_full == per_full);
  assign hit_lo   = (seg_cnt[0] == per_q[0]);
  assign hit_hi   = (seg_cnt[1] == per_q[1]);
  assign wrap_lo  = pair_mode ? hit32 : hit_lo;

  assign seg_load[0] = wr_en && addr == A_CNT_LO;
  assign seg_load[1] = wr_en && (addr == A_CNT_HI || (addr == A_CNT_LO && pair_mode));
  assign seg_val[0]  = wdata[SEG_W-1:0];
  assign seg_val[1]  = (addr == A_CNT_LO) ? wdata[DATA_W-1:SEG_W] : wdata[SEG_W-1:0];
  assign seg_wrap[0] = wrap_lo;
  assign seg_wrap[1] = pair_mode ? hit32 : hit_hi;
  assign seg_step[0] = 1'b1;
  assign seg_step[1] = pair_mode ? (seg_cnt[0] == {SEG_W{1'b1}}) : 1'b1;

  for (genvar g = 0; g < 2; g++) begin : g_seg
    tmr_segment #(.W(SEG_W)) u_seg (
      .clk(clk), .rst_n(rst_n), .load(seg_load[g]), .load_val(seg_val[g]),
      .tick(tick), .wrap(seg_wrap[g]), .step(seg_step[g]), .cnt(seg_cnt[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q[0] <= '1;
      per_q[1] <= '1;
    end else if (wr_en) begin
      if (addr == A_PER_LO) begin
        per_q[0] <= wdata[SEG_W-1:0];
        if (pair_mode) per_q[1] <= wdata[DATA_W-1:SEG_W];
      end else if (addr == A_PER_HI) begin
        per_q[1] <= wdata[SEG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= '0;
    else begin
      match_q[0] <= tick && wrap_lo && !cnt_wr;
      match_q[1] <= tick && !pair_mode && hit_hi && !cnt_wr;
    end
  end
  assign match_pulse = match_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL, A_SET, A_CLR: rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      A_CNT_LO: rdata = pair_mode ? cnt_full : {{SEG_W{1'b0}}, seg_cnt[0]};
      A_CNT_HI: rdata = {{SEG_W{1'b0}}, seg_cnt[1]};
      A_PER_LO: rdata = pair_mode ? per_full : {{SEG_W{1'b0}}, per_q[0]};
      A_PER_HI: rdata = {{SEG_W{1'b0}}, per_q[1]};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_on,
  input logic              gate_en,
  input logic              gate_s,
  input logic              pair_mode,
  input logic              tick,
  input logic              cnt_wr,
  input logic              wrap_lo,
  input logic [DATA_W-1:0] cnt_full,
  input logic [PRE_W-1:0]  pre_cnt,
  input logic [PRE_W:0]    ratio,
  input logic [1:0]        match_pulse
);
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pre_cnt} < ratio);

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pair_mode && !wrap_lo && !cnt_wr) |=> cnt_full == $past(cnt_full) + 1'b1);

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wrap_lo && !cnt_wr) |=> (cnt_full[DATA_W/2-1:0] == '0) && match_pulse[0]);

  p_pulse_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse[0] |-> cnt_full[DATA_W/2-1:0] == '0);

  p_pair_no_hi_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_mode && $past(pair_mode)) |-> !match_pulse[1]);

  p_gate_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !gate_s) |-> !tick);

  p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_on && !cnt_wr) |=> $stable(cnt_full));
endmodule

bind gated_period_timer tmr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_on(ctrl_on), .gate_en(gate_en),
  .gate_s(gate_s), .pair_mode(pair_mode), .tick(tick), .cnt_wr(cnt_wr),
  .wrap_lo(wrap_lo), .cnt_full(cnt_full), .pre_cnt(pre_cnt), .ratio(ratio),
  .match_pulse(match_pulse));

// File: tb/test_gated_period_timer.sv
module test_gated_period_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ext_clk_in = 1'b0;
  logic        gate_in = 1'b0;
  logic [1:0]  match_pulse;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  gated_period_timer i_gated_period_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_clk_in(ext_clk_in), .gate_in(gate_in),
    .match_pulse(match_pulse));

  // prescale code, edges after enable, expected count (R3)
  localparam int unsigned TBL [8][3] = '{
    '{0, 10, 10}, '{1, 10, 5}, '{2, 11, 2}, '{3, 17, 2},
    '{4, 33, 2},  '{5, 64, 2}, '{6, 200, 3}, '{7, 600, 2}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input logic [31:0] ctrl);
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd0, ctrl);
  endtask

  logic [31:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd3, v); check("R1 count", v, 32'h0);
    rd(3'd5, v); check("R1 period lo", v, 32'h0000FFFF);
    rd(3'd6, v); check("R1 period hi", v, 32'h0000FFFF);
    check("R1 pulse", {30'd0, match_pulse}, 32'h0);

    wr(3'd0, 32'h0000FFFF); rd(3'd0, v); check("R2 mask", v, 32'h000080FA);
    wr(3'd2, 32'h00000070); rd(3'd0, v); check("R2 clr", v, 32'h0000808A);
    wr(3'd0, 32'h000000C8); wr(3'd1, 32'h00008000);
    rd(3'd0, v); check("R2 set", v, 32'h000080C8);
    wr(3'd0, 32'h0);

    for (int i = 0; i < 8; i++) begin
      restart(32'h8000 | (TBL[i][0] << 4));
      step(int'(TBL[i][1]));
      rd(3'd3, v);
      check($sformatf("R3 code %0d", TBL[i][0]), v, TBL[i][2]);
    end

    wr(3'd0, 32'h0); wr(3'd3, 32'h0); wr(3'd5, 32'd5);
    wr(3'd0, 32'h8010);
    step(10); rd(3'd3, v); check("R4 reach", v, 32'd5);
    step(1);  rd(3'd3, v); check("R4 hold", v, 32'd5);
    check("R5 no early pulse", {30'd0, match_pulse}, 32'd0);
    step(1);  rd(3'd3, v); check("R4 wrap", v, 32'd0);
    check("R5 pulse", {30'd0, match_pulse}, 32'd1);
    step(1);  check("R5 pulse one cycle", {30'd0, match_pulse}, 32'd0);

    wr(3'd0, 32'h0); wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    wr(3'd5, 32'd2); wr(3'd6, 32'd4);
    wr(3'd0, 32'h8000);
    step(3); rd(3'd3, v); check("R7 lo wrap", v, 32'd0);
    check("R7 lo pulse", {30'd0, match_pulse}, 32'd1);
    rd(3'd4, v); check("R7 hi", v, 32'd3);
    step(2); rd(3'd4, v); check("R7 hi wrap", v, 32'd0);
    check("R7 hi pulse", {30'd0, match_pulse}, 32'd2);

    wr(3'd5, 32'h0000FFFF);
    restart(32'h8080);
    step(10); rd(3'd3, v); check("R8 gate low", v, 32'd0);
    gate_in = 1'b1;
    step(2); rd(3'd3, v); check("R8 sync delay", v, 32'd0);
    step(8); rd(3'd3, v); check("R8 gate high", v, 32'd8);
    gate_in = 1'b0;
    step(10); rd(3'd3, v); check("R8 gate fall", v, 32'd10);

    restart(32'h8020);
    step(6); rd(3'd3, v); check("R9 running", v, 32'd1);
    wr(3'd2, 32'h8000);
    step(20); rd(3'd3, v); check("R9 frozen", v, 32'd1);
    wr(3'd1, 32'h8000);
    step(3); rd(3'd3, v); check("R9 prescaler cleared", v, 32'd1);
    step(1); rd(3'd3, v); check("R9 first tick", v, 32'd2);

    restart(32'h8002);
    step(4); rd(3'd3, v); check("R10 idle", v, 32'd0);
    ext_clk_in = 1'b1;
    step(2); rd(3'd3, v); check("R10 sync delay", v, 32'd0);
    step(1); rd(3'd3, v); check("R10 first edge", v, 32'd1);
    for (int k = 0; k < 4; k++) begin
      ext_clk_in = 1'b0; step(3);
      ext_clk_in = 1'b1; step(3);
    end
    step(5); rd(3'd3, v); check("R10 edges only", v, 32'd5);

    wr(3'd0, 32'h0008);
    wr(3'd3, 32'h0000FFFE);
    wr(3'd5, 32'hFFFFFFFF);
    rd(3'd6, v); check("R6 period pair load", v, 32'h0000FFFF);
    wr(3'd1, 32'h8000);
    step(2); rd(3'd3, v); check("R6 carry", v, 32'h00010000);
    rd(3'd4, v); check("R6 hi read", v, 32'h1);
    wr(3'd3, 32'hFFFFFFFE);
    step(1); rd(3'd3, v); check("R6 match value", v, 32'hFFFFFFFF);
    step(1); rd(3'd3, v); check("R6 32-bit wrap", v, 32'h0);
    check("R6 pulse bit0 only", {30'd0, match_pulse}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule